// File: doc/BRIEF.md
# Slow-Clock Timer Domain Bridge

This block couples an 8-bit timer/counter to a processor-side register interface. The counter runs on its own slow timer clock, which has no phase relation to the processor clock. Processor writes to the compare value and to the control field are not applied directly. Each write is parked in a processor-domain holding register and carried into the timer domain by a toggle handshake. While that transfer is in flight, a per-register busy output stays high. Software must not rely on the new value until that output drops. A write to a register whose transfer is still in flight is dropped.

Two timer events are returned to the processor domain: counter wrap and compare equality. Each event is first registered for one timer cycle. It is then resynchronised, and it sets a sticky flag that a one-bit write clears. Each flag has a registered interrupt output gated by its own enable. The counter value reaches the processor as a snapshot taken on every timer edge, so a read always returns a value held at the most recent timer edge.

A safe way to read the counter is to write the control or compare register, wait for its busy output to fall, and then read the snapshot. The compare pin toggles on the timer clock and is not retimed to the processor clock.

Top module: `tmr_bridge`

## Requirements
- R1: While either reset is held, and on its release, busy_cmp, busy_ctl, flags, irq, cnt_rd and cmp_pin are all zero. Both resets are synchronous and active high.
- R2: A write strobe (wr_cmp or wr_ctl) to a register whose busy output is low raises that busy output on the next processor cycle. The busy output falls only after the new value is in effect in the timer domain, within a few timer cycles.
- R3: A write strobe to a register whose busy output is high is dropped. The earlier value is the one that takes effect, and the busy output stays high until that earlier transfer completes.
- R4: Control bit 0 (run) makes the counter advance by one on every timer edge. While run is 0 the counter holds its value.
- R5: flags bit 0 sets when the running counter wraps from 255 to 0. flags bit 1 sets when the running counter equals the compare value at a timer edge.
- R6: A flag becomes visible one timer cycle plus the synchronizer delay after its event. At that point cnt_rd is already 1 to 3 counts past the counter value at which the event fired.
- R7: A one on flag_clr bit i clears flags bit i on the next processor cycle, unless a new event sets it in that same cycle. Without a clear, a set flag stays set.
- R8: irq bit i is a registered copy of flags bit i ANDed with irq_en bit i, one processor cycle behind.
- R9: cnt_rd changes only when a new timer-edge snapshot arrives. With the counter stopped, a read taken after a control write's busy output falls stays constant.
- R10: When control bit 1 (pin enable) is set, cmp_pin toggles on the timer edge at which a compare match occurs. Otherwise cmp_pin holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor clock |
| cpu_rst | input | 1 | Processor-domain synchronous reset, active high |
| tmr_clk | input | 1 | Slow timer clock |
| tmr_rst | input | 1 | Timer-domain synchronous reset, active high |
| wr_cmp | input | 1 | Write strobe for the compare value |
| wr_ctl | input | 1 | Write strobe for the control field (bit 0 run, bit 1 pin enable) |
| wr_data | input | CNT_W | Write data for either register |
| busy_cmp | output | 1 | Compare transfer in flight |
| busy_ctl | output | 1 | Control transfer in flight |
| flag_clr | input | 2 | Write-one-to-clear for flags |
| irq_en | input | 2 | Per-flag interrupt enable |
| flags | output | 2 | Bit 0 wrap, bit 1 compare match |
| irq | output | 2 | Registered flag AND enable |
| cnt_rd | output | CNT_W | Last counter snapshot in the processor domain |
| cmp_pin | output | 1 | Compare output, timer-clock timed |

## Verification
The assertions assume that the timer clock is several times slower than the processor clock. Under that condition a snapshot or a holding register stays stable for many processor cycles after its toggle is seen. They also assume that write strobes are single-cycle pulses. The bench keeps a timer period of about thirteen processor cycles and drives every strobe for exactly one processor cycle. Its random bursts are allowed to collide with in-flight transfers on purpose, so that the dropped-write path is exercised.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
  localparam int NUM_EV  = 2;
  localparam int EV_OVF  = 0;
  localparam int EV_CMP  = 1;
  localparam int CTL_W   = 2;
  localparam int CTL_RUN = 0;
  localparam int CTL_PIN = 1;
endpackage

// File: rtl/tbr_sync.sv
module tbr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tbr_xfer.sv
module tbr_xfer #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         cpu_clk,
  input  logic         cpu_rst,
  input  logic         tmr_clk,
  input  logic         tmr_rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic         busy,
  output logic [W-1:0] tmr_val
);
  logic [W-1:0] hold;
  logic         req_tgl, ack_tgl;
  logic         req_s, ack_s;
  logic         accept;

  assign accept = wr && !busy;

  // processor side: park the value, flip the request
  always_ff @(posedge cpu_clk) begin
    if (cpu_rst) begin
      hold    <= '0;
      req_tgl <= 1'b0;
      busy    <= 1'b0;
    end else if (accept) begin
      hold    <= wdata;
      req_tgl <= ~req_tgl;
      busy    <= 1'b1;
    end else if (ack_s == req_tgl) begin
      busy    <= 1'b0;
    end
  end

  tbr_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(tmr_clk), .rst(tmr_rst), .d(req_tgl), .q(req_s)
  );

  // timer side: take the parked value, return the toggle
  always_ff @(posedge tmr_clk) begin
    if (tmr_rst) begin
      tmr_val <= '0;
      ack_tgl <= 1'b0;
    end else if (req_s != ack_tgl) begin
      tmr_val <= hold;
      ack_tgl <= req_s;
    end
  end

  tbr_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(cpu_clk), .rst(cpu_rst), .d(ack_tgl), .q(ack_s)
  );

  // R2: an accepted write raises busy
  a_r2_busy_set: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    accept |=> busy);

  // R3: a write during a transfer leaves the parked value alone
  a_r3_hold_kept: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    (wr && busy) |=> $stable(hold));

  // R2: busy stays up while the acknowledge has not returned
  a_r2_busy_waits: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    (busy && ack_s != req_tgl) |=> busy);
endmodule

// File: rtl/tbr_count.sv
module tbr_count
  import tbr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      cmp_val,
  input  logic [CTL_W-1:0]  ctl_val,
  output logic [W-1:0]      cnt,
  output logic [NUM_EV-1:0] ev_tgl,
  output logic              pin
);
  logic [NUM_EV-1:0] ev_q;
  logic              run, pin_en, hit, wrap;

  assign run    = ctl_val[CTL_RUN];
  assign pin_en = ctl_val[CTL_PIN];
  assign hit    = run && (cnt == cmp_val);
  assign wrap   = run && (cnt == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      ev_q   <= '0;
      ev_tgl <= '0;
      pin    <= 1'b0;
    end else begin
      ev_q         <= '0;
      ev_q[EV_OVF] <= wrap;
      ev_q[EV_CMP] <= hit;
      ev_tgl       <= ev_tgl ^ ev_q;
      if (run)           cnt <= cnt + 1'b1;
      if (hit && pin_en) pin <= ~pin;
    end
  end

  // R4: a stopped counter holds
  a_r4_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt));

  // R5: wrap produces an event one timer cycle later
  a_r5_wrap_event: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0) && ev_q[EV_OVF]);

  // R10: the pin moves only on an enabled match
  a_r10_pin_quiet: assert property (@(posedge clk) disable iff (rst)
    !(hit && pin_en) |=> $stable(pin));
endmodule

// File: rtl/tbr_snap.sv
module tbr_snap #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         cpu_clk,
  input  logic         cpu_rst,
  input  logic         tmr_clk,
  input  logic         tmr_rst,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] cnt_rd
);
  logic [W-1:0] snap_q;
  logic         snap_tgl, tgl_s, tgl_d, upd;

  always_ff @(posedge tmr_clk) begin
    if (tmr_rst) begin
      snap_q   <= '0;
      snap_tgl <= 1'b0;
    end else begin
      snap_q   <= cnt;
      snap_tgl <= ~snap_tgl;
    end
  end

  tbr_sync #(.STAGES(STAGES)) u_tgl_sync (
    .clk(cpu_clk), .rst(cpu_rst), .d(snap_tgl), .q(tgl_s)
  );

  assign upd = tgl_s ^ tgl_d;

  always_ff @(posedge cpu_clk) begin
    if (cpu_rst) begin
      tgl_d  <= 1'b0;
      cnt_rd <= '0;
    end else begin
      tgl_d <= tgl_s;
      if (upd) cnt_rd <= snap_q;
    end
  end

  // R9: the read value moves only on a fresh snapshot
  a_r9_snap_stable: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    !upd |=> $stable(cnt_rd));
endmodule

// File: rtl/tbr_flag.sv
module tbr_flag #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ev_tgl,
  input  logic clr,
  input  logic en,
  output logic flag,
  output logic irq
);
  logic s, s_d, set;

  tbr_sync #(.STAGES(STAGES)) u_ev_sync (
    .clk(clk), .rst(rst), .d(ev_tgl), .q(s)
  );

  assign set = s ^ s_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_d  <= 1'b0;
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      s_d  <= s;
      flag <= set | (flag & ~clr);
      irq  <= flag & en;
    end
  end

  // R7: a clear without a new event drops the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag);

  // R7: without a clear the flag is sticky
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);

  // R8: an interrupt needs its enable
  a_r8_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(en));
endmodule

// File: rtl/tmr_bridge.sv
module tmr_bridge
  import tbr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              cpu_clk,
  input  logic              cpu_rst,
  input  logic              tmr_clk,
  input  logic              tmr_rst,
  input  logic              wr_cmp,
  input  logic              wr_ctl,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              busy_cmp,
  output logic              busy_ctl,
  input  logic [NUM_EV-1:0] flag_clr,
  input  logic [NUM_EV-1:0] irq_en,
  output logic [NUM_EV-1:0] flags,
  output logic [NUM_EV-1:0] irq,
  output logic [CNT_W-1:0]  cnt_rd,
  output logic              cmp_pin
);
  logic [CNT_W-1:0]  tmr_cmp, tmr_cnt;
  logic [CTL_W-1:0]  tmr_ctl;
  logic [NUM_EV-1:0] ev_tgl;

  tbr_xfer #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_cmp_xfer (
    .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .tmr_clk(tmr_clk), .tmr_rst(tmr_rst),
    .wr(wr_cmp), .wdata(wr_data), .busy(busy_cmp), .tmr_val(tmr_cmp)
  );

  tbr_xfer #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_ctl_xfer (
    .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .tmr_clk(tmr_clk), .tmr_rst(tmr_rst),
    .wr(wr_ctl), .wdata(wr_data[CTL_W-1:0]), .busy(busy_ctl), .tmr_val(tmr_ctl)
  );

  tbr_count #(.W(CNT_W)) u_count (
    .clk(tmr_clk), .rst(tmr_rst), .cmp_val(tmr_cmp), .ctl_val(tmr_ctl),
    .cnt(tmr_cnt), .ev_tgl(ev_tgl), .pin(cmp_pin)
  );

  tbr_snap #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_snap (
    .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .tmr_clk(tmr_clk), .tmr_rst(tmr_rst),
    .cnt(tmr_cnt), .cnt_rd(cnt_rd)
  );

  for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
    tbr_flag #(.STAGES(SYNC_STAGES)) u_flag (
      .clk(cpu_clk), .rst(cpu_rst), .ev_tgl(ev_tgl[i]), .clr(flag_clr[i]),
      .en(irq_en[i]), .flag(flags[i]), .irq(irq[i])
    );
  end
endmodule

// File: tb/tmr_bridge_tb.sv
`timescale 1ns/1ps
module tmr_bridge_tb;
  logic       cpu_clk = 0, tmr_clk = 0;
  logic       cpu_rst = 1, tmr_rst = 1;
  logic       wr_cmp = 0, wr_ctl = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] flag_clr = 0, irq_en = 0;
  logic       busy_cmp, busy_ctl, cmp_pin;
  logic [1:0] flags, irq;
  logic [7:0] cnt_rd;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2     cpu_clk = ~cpu_clk;
  always #26.5  tmr_clk = ~tmr_clk;

  tmr_bridge u_dut (
    .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .tmr_clk(tmr_clk), .tmr_rst(tmr_rst),
    .wr_cmp(wr_cmp), .wr_ctl(wr_ctl), .wr_data(wr_data),
    .busy_cmp(busy_cmp), .busy_ctl(busy_ctl), .flag_clr(flag_clr), .irq_en(irq_en),
    .flags(flags), .irq(irq), .cnt_rd(cnt_rd), .cmp_pin(cmp_pin)
  );

  function automatic bit in_window(logic [7:0] v, logic [7:0] base);
    logic [7:0] d = v - base;
    return (d >= 8'd1) && (d <= 8'd3);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge cpu_clk);
  endtask

  task automatic write(bit ctl, logic [7:0] d);
    @(negedge cpu_clk);
    wr_data = d;
    if (ctl) wr_ctl = 1; else wr_cmp = 1;
    @(negedge cpu_clk);
    wr_cmp = 0; wr_ctl = 0;
  endtask

  task automatic wait_idle(bit ctl, output bit ok);
    ok = 0;
    for (int i = 0; i < 300; i++) begin
      if (!(ctl ? busy_ctl : busy_cmp)) begin ok = 1; break; end
      @(negedge cpu_clk);
    end
  endtask

  task automatic wait_flag(int idx, output bit ok);
    ok = 0;
    for (int i = 0; i < 6000; i++) begin
      if (flags[idx]) begin ok = 1; break; end
      @(negedge cpu_clk);
    end
  endtask

  task automatic clear_flags(logic [1:0] m);
    @(negedge cpu_clk);
    flag_clr = m;
    @(negedge cpu_clk);
    flag_clr = 0;
  endtask

  initial begin
    #700us;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit ok;
    logic [7:0] v1, v2, x;
    void'($urandom(32'd4711));

    repeat (4) @(posedge tmr_clk);
    cyc(2);
    // R1: all outputs zero during reset
    chk(!busy_cmp && !busy_ctl && flags == 0 && irq == 0 && cnt_rd == 0 && !cmp_pin,
        "R1 reset", {busy_cmp, busy_ctl, flags, irq, cmp_pin}, 0);
    cpu_rst = 0; tmr_rst = 0;
    cyc(3);
    chk(!busy_cmp && flags == 0 && cnt_rd == 0, "R1 after release", cnt_rd, 0);

    // R2: write compare 20; R3: a second write while busy is dropped
    write(0, 8'd20);
    chk(busy_cmp, "R2 busy raised", busy_cmp, 1);
    write(0, 8'd200);
    chk(busy_cmp, "R3 busy held", busy_cmp, 1);
    wait_idle(0, ok);
    chk(ok, "R2 busy falls", busy_cmp, 0);

    // run with pin enable, compare interrupt enabled
    irq_en = 2'b10;
    write(1, 8'd3);
    wait_idle(1, ok);
    chk(ok, "R2 ctl busy falls", busy_ctl, 0);
    wait_flag(1, ok);
    chk(ok, "R5 compare flag", flags[1], 1);
    // R3 + R6: the match fired at 20, not 200
    chk(in_window(cnt_rd, 8'd20), "R3 R6 count past match", cnt_rd, 21);
    cyc(2);
    chk(irq == 2'b10, "R8 irq gated", irq, 2);
    chk(cmp_pin, "R10 pin toggled", cmp_pin, 1);

    // R7: clear the compare flag
    clear_flags(2'b10);
    chk(!flags[1], "R7 flag cleared", flags[1], 0);
    cyc(1);
    chk(irq == 0, "R8 irq follows clear", irq, 0);

    // R5: wrap flag
    wait_flag(0, ok);
    chk(ok, "R5 wrap flag", flags[0], 1);
    chk(in_window(cnt_rd, 8'd255), "R6 count past wrap", cnt_rd, 0);
    cyc(2);
    chk(irq == 0, "R8 wrap irq masked", irq, 0);

    // R4 + R9: stop, safe read sequence, value holds
    write(1, 8'd2);
    wait_idle(1, ok);
    repeat (3) @(posedge tmr_clk);
    cyc(8);
    v1 = cnt_rd;
    cyc(300);
    v2 = cnt_rd;
    chk(v1 == v2, "R4 R9 stopped read stable", v2, v1);
    chk(cmp_pin, "R10 pin holds while stopped", cmp_pin, 1);

    // R2 R3: random write bursts, some hitting busy
    for (int i = 0; i < 24; i++) begin
      bit was_busy;
      cyc($urandom_range(0, 20));
      was_busy = busy_cmp;
      write(0, 8'($urandom));
      if (!was_busy) chk(busy_cmp, "R2 random accept", busy_cmp, 1);
      else           chk(busy_cmp, "R3 random drop keeps busy", busy_cmp, 1);
    end
    wait_idle(0, ok);
    chk(ok, "R2 random drain", busy_cmp, 0);

    // R5 R6: random compare values, run until match
    for (int i = 0; i < 5; i++) begin
      x = 8'($urandom);
      write(0, x);
      wait_idle(0, ok);
      clear_flags(2'b11);
      write(1, 8'd1);
      wait_flag(1, ok);
      chk(ok, "R5 random match", flags[1], 1);
      chk(in_window(cnt_rd, x), "R6 random window", cnt_rd, int'(x) + 1);
      write(1, 8'd0);
      wait_idle(1, ok);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule